// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block produces the complete timing of a 2:1 interlaced television raster from one master clock. The clock is qualified by an enable input, and each enabled cycle is one tick. A scan line lasts 32 ticks. The vertical position is counted in half-lines of 16 ticks, so the odd number of lines per frame divides evenly into two fields. The second field starts halfway along a line.

From these two counters the block decodes four outputs. The first is a mixed sync waveform carrying horizontal sync, equalizing pulses and serrated vertical sync. The others are a plain horizontal sync, a vertical drive that covers the serrated pulses, and a frame pulse that marks the first half-line of the odd field. A select input chooses 525-line or 625-line timing. Two strobes move the vertical count to a fixed point of the vertical interval, either the first equalizing pulse or the first vertical pulse. This lets the raster be brought into step with an outside vertical reference while the horizontal phase continues unbroken.

Top module: `ilace_sync_gen`

## Requirements
- R1: `hsync_no` is low for ticks 0 and 1 of every 32-tick line and high for ticks 2 to 31, with no interruption during the vertical interval.
- R2: A frame is 2L half-lines, with L = 525 when the standard flag is 0 and L = 625 when it is 1. Field one covers half-lines 0 to L-1 and field two covers half-lines L to 2L-1. The frame pulse therefore repeats every 16·2L ticks.
- R3: Outside the vertical interval, `msync_no` equals `hsync_no`.
- R4: Field offsets 0–5 and 12–17 are equalizing half-lines. The offset is the half-line count minus the start of its field. In these half-lines `msync_no` is low for tick 0 of the half-line (tick position modulo 16) and high for ticks 1 to 15.
- R5: Field offsets 6–11 are serrated vertical half-lines. In these `msync_no` is low for ticks 0 to 13 of the half-line and high for ticks 14 and 15.
- R6: `frame_o` is high during half-line 0 and low elsewhere.
- R7: `vdrive_o` is high during field offsets 6–11 of both fields and low elsewhere.
- R8: In a cycle with `tick_en_i` low, no counter moves and all outputs hold their values.
- R9: `std625_i` is sampled only when the half-line count enters 0 and during reset. A change in mid-frame leaves the current frame length unchanged.
- R10: A high level on `vrst_eq_i` in any cycle is held as a request. The request is applied on the next tick that ends a line (tick 31). At that tick the half-line count becomes 0 and the standard flag is sampled.
- R11: A request from `vrst_vs_i` is held and applied in the same way, but the half-line count becomes 6. If both requests are pending, the `vrst_eq_i` target wins. Applying a request clears both. The tick counter is never moved by a request.
- R12: A synchronous active-low reset puts the raster at tick 0 of half-line 0 and samples `std625_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_en_i | input | 1 | Clock qualifier; one tick per high cycle, 32 per line |
| std625_i | input | 1 | Line standard: 0 selects 525 lines, 1 selects 625 lines |
| vrst_eq_i | input | 1 | Request a jump to the first equalizing half-line |
| vrst_vs_i | input | 1 | Request a jump to the first serrated vertical half-line |
| msync_no | output | 1 | Mixed sync, active low |
| hsync_no | output | 1 | Horizontal sync, active low |
| vdrive_o | output | 1 | Vertical drive, high during the serrated half-lines |
| frame_o | output | 1 | Odd-field frame pulse, high during half-line 0 |

## Verification
A fault in the tick counter appears on `hsync_no` within one line of 32 ticks, as a pulse that is misplaced or too wide. A fault in the half-line counter, or a wrong standard flag, is harder to see. It may show only at the next vertical interval as misplaced equalizing or serrated pulses, or only at the next frame pulse as a wrong frame length. For that reason the sweeps cover whole frames in both standards. A request that is lost or applied too early changes how many ticks pass before `frame_o` or `vdrive_o` rises, so the bench measures that count exactly against the tick position at which the strobe was given.

// File: rtl/sg_pkg.sv
// Shared types for the interlaced sync generator.
// Assumes nothing beyond the 1800-2017 language.
package sg_pkg;

    // Classification of the current half-line for the mixed sync decoder.
    typedef enum logic [1:0] {
        SEG_PLAIN   = 2'd0,
        SEG_EQUAL   = 2'd1,
        SEG_SERRATE = 2'd2
    } seg_e;

endpackage

// File: rtl/sg_hcount.sv
// Tick counter within one scan line.
// Advances once per enabled tick and wraps after LINE_TICKS ticks.
// Flags the final tick of each half-line and of each line; both flags are
// already qualified by the tick enable.
// Assumes LINE_TICKS is an even power of two.
module sg_hcount #(
    parameter int LINE_TICKS = 32,
    localparam int HW = $clog2(LINE_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    output logic [HW-1:0] hcnt_o,
    output logic          half_end_o,
    output logic          line_end_o
);
    localparam logic [HW-1:0] LAST_TICK = HW'(LINE_TICKS - 1);
    localparam logic [HW-1:0] MID_TICK  = HW'(LINE_TICKS / 2 - 1);

    logic [HW-1:0] hcnt_q;

    // Decode the end-of-half-line and end-of-line ticks.
    always_comb begin
        half_end_o = tick_en && (hcnt_q == MID_TICK);
        line_end_o = tick_en && (hcnt_q == LAST_TICK);
    end

    // Count ticks across the line and wrap at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q <= '0;
        end else if (tick_en) begin
            hcnt_q <= (hcnt_q == LAST_TICK) ? '0 : hcnt_q + 1'b1;
        end
    end

    assign hcnt_o = hcnt_q;

endmodule

// File: rtl/sg_vcount.sv
// Half-line counter across one interlaced frame.
// Steps on each half-line end. It wraps after 2*L half-lines, where L comes
// from the standard flag latched at the start of the frame.
// Vertical-reset requests are held until the next line end and then load a
// fixed half-line count. The equalizing target wins over the vertical target.
// Assumes both line counts are odd, so every wrap falls on a line end.
module sg_vcount #(
    parameter int LINES_A   = 525,
    parameter int LINES_B   = 625,
    parameter int VS_TARGET = 6,
    localparam int VW = $clog2(2 * LINES_B)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_end,
    input  logic          line_end,
    input  logic          std_sel_i,
    input  logic          req_eq_i,
    input  logic          req_vs_i,
    output logic [VW-1:0] vcnt_o,
    output logic          std_o
);
    localparam logic [VW-1:0] LAST_A = VW'(2 * LINES_A - 1);
    localparam logic [VW-1:0] LAST_B = VW'(2 * LINES_B - 1);
    localparam logic [VW-1:0] VS_CNT = VW'(VS_TARGET);

    logic [VW-1:0] vcnt_q;
    logic          std_q;
    logic          pend_eq_q;
    logic          pend_vs_q;
    logic          want_eq;
    logic          want_vs;
    logic [VW-1:0] last_cnt;

    // Merge held requests with the strobes of this cycle and pick the wrap point.
    always_comb begin
        want_eq  = pend_eq_q || req_eq_i;
        want_vs  = pend_vs_q || req_vs_i;
        last_cnt = std_q ? LAST_B : LAST_A;
    end

    // Advance, wrap or jump the half-line count, and latch the standard at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt_q    <= '0;
            std_q     <= std_sel_i;
            pend_eq_q <= 1'b0;
            pend_vs_q <= 1'b0;
        end else if (line_end) begin
            pend_eq_q <= 1'b0;
            pend_vs_q <= 1'b0;
            if (want_eq) begin
                vcnt_q <= '0;
                std_q  <= std_sel_i;
            end else if (want_vs) begin
                vcnt_q <= VS_CNT;
            end else if (vcnt_q == last_cnt) begin
                vcnt_q <= '0;
                std_q  <= std_sel_i;
            end else begin
                vcnt_q <= vcnt_q + 1'b1;
            end
        end else begin
            pend_eq_q <= want_eq;
            pend_vs_q <= want_vs;
            if (half_end) begin
                vcnt_q <= vcnt_q + 1'b1;
            end
        end
    end

    assign vcnt_o = vcnt_q;
    assign std_o  = std_q;

endmodule

// File: rtl/sg_wave.sv
// Output decoder.
// Maps the tick and half-line counts to mixed sync, horizontal sync, vertical
// drive and the odd-field frame pulse. It is purely combinational on the
// registered counts, so every output edge follows a clock edge.
// Assumes the field start equals the line count L (half-lines).
module sg_wave
    import sg_pkg::*;
#(
    parameter int LINE_TICKS  = 32,
    parameter int HSYNC_TICKS = 2,
    parameter int EQ_TICKS    = 1,
    parameter int SERR_HIGH   = 2,
    parameter int LINES_A     = 525,
    parameter int LINES_B     = 625,
    parameter int PRE_EQ      = 6,
    parameter int VS_PULSES   = 6,
    parameter int POST_EQ     = 6,
    localparam int HW = $clog2(LINE_TICKS),
    localparam int VW = $clog2(2 * LINES_B)
) (
    input  logic [HW-1:0] hcnt_i,
    input  logic [VW-1:0] vcnt_i,
    input  logic          std_i,
    output logic          msync_n,
    output logic          hsync_n,
    output logic          vdrive,
    output logic          frame
);
    localparam int PW         = HW - 1;
    localparam int HALF_TICKS = LINE_TICKS / 2;
    localparam int VS_END     = PRE_EQ + VS_PULSES;
    localparam int VI_END     = VS_END + POST_EQ;

    localparam logic [VW-1:0] FLD_A   = VW'(LINES_A);
    localparam logic [VW-1:0] FLD_B   = VW'(LINES_B);
    localparam logic [VW-1:0] OFF_VS  = VW'(PRE_EQ);
    localparam logic [VW-1:0] OFF_EQ2 = VW'(VS_END);
    localparam logic [VW-1:0] OFF_END = VW'(VI_END);
    localparam logic [HW-1:0] HS_LEN  = HW'(HSYNC_TICKS);
    localparam logic [PW-1:0] EQ_LEN  = PW'(EQ_TICKS);
    localparam logic [PW-1:0] SR_LEN  = PW'(HALF_TICKS - SERR_HIGH);

    logic [VW-1:0] fld_len;
    logic [VW-1:0] offset;
    logic [PW-1:0] pos;
    seg_e          seg;

    // Locate the half-line within its field and the tick within its half-line.
    always_comb begin
        fld_len = std_i ? FLD_B : FLD_A;
        offset  = (vcnt_i >= fld_len) ? (vcnt_i - fld_len) : vcnt_i;
        pos     = hcnt_i[PW-1:0];
    end

    // Classify the half-line as plain, equalizing or serrated.
    always_comb begin
        if (offset < OFF_VS) begin
            seg = SEG_EQUAL;
        end else if (offset < OFF_EQ2) begin
            seg = SEG_SERRATE;
        end else if (offset < OFF_END) begin
            seg = SEG_EQUAL;
        end else begin
            seg = SEG_PLAIN;
        end
    end

    // Shape the active-low pulses for the current segment.
    always_comb begin
        hsync_n = !(hcnt_i < HS_LEN);
        unique case (seg)
            SEG_EQUAL:   msync_n = !(pos < EQ_LEN);
            SEG_SERRATE: msync_n = !(pos < SR_LEN);
            default:     msync_n = hsync_n;
        endcase
        vdrive = (seg == SEG_SERRATE);
        frame  = (vcnt_i == '0);
    end

endmodule

// File: rtl/ilace_sync_gen.sv
// Interlaced composite sync generator, top level.
// Chains the tick counter, the half-line counter and the output decoder.
// Assumes a master clock qualified to 32 ticks per line.
module ilace_sync_gen #(
    parameter int LINE_TICKS  = 32,
    parameter int HSYNC_TICKS = 2,
    parameter int EQ_TICKS    = 1,
    parameter int SERR_HIGH   = 2,
    parameter int LINES_A     = 525,
    parameter int LINES_B     = 625,
    parameter int PRE_EQ      = 6,
    parameter int VS_PULSES   = 6,
    parameter int POST_EQ     = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_en_i,
    input  logic std625_i,
    input  logic vrst_eq_i,
    input  logic vrst_vs_i,
    output logic msync_no,
    output logic hsync_no,
    output logic vdrive_o,
    output logic frame_o
);
    localparam int HW = $clog2(LINE_TICKS);
    localparam int VW = $clog2(2 * LINES_B);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          half_end;
    logic          line_end;
    logic          std_q;

    sg_hcount #(.LINE_TICKS(LINE_TICKS)) u_hcount (
        .clk        (clk_i),
        .rst_n      (rst_ni),
        .tick_en    (tick_en_i),
        .hcnt_o     (hcnt),
        .half_end_o (half_end),
        .line_end_o (line_end)
    );

    sg_vcount #(
        .LINES_A   (LINES_A),
        .LINES_B   (LINES_B),
        .VS_TARGET (PRE_EQ)
    ) u_vcount (
        .clk       (clk_i),
        .rst_n     (rst_ni),
        .half_end  (half_end),
        .line_end  (line_end),
        .std_sel_i (std625_i),
        .req_eq_i  (vrst_eq_i),
        .req_vs_i  (vrst_vs_i),
        .vcnt_o    (vcnt),
        .std_o     (std_q)
    );

    sg_wave #(
        .LINE_TICKS  (LINE_TICKS),
        .HSYNC_TICKS (HSYNC_TICKS),
        .EQ_TICKS    (EQ_TICKS),
        .SERR_HIGH   (SERR_HIGH),
        .LINES_A     (LINES_A),
        .LINES_B     (LINES_B),
        .PRE_EQ      (PRE_EQ),
        .VS_PULSES   (VS_PULSES),
        .POST_EQ     (POST_EQ)
    ) u_wave (
        .hcnt_i  (hcnt),
        .vcnt_i  (vcnt),
        .std_i   (std_q),
        .msync_n (msync_no),
        .hsync_n (hsync_no),
        .vdrive  (vdrive_o),
        .frame   (frame_o)
    );

endmodule

// File: rtl/ilace_sync_gen_chk.sv
// Property checker for the interlaced sync generator, bound to the top.
// Observes the ports plus the line-end flag and the latched standard.
module ilace_sync_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic msync_n,
    input logic hsync_n,
    input logic vdrive,
    input logic frame,
    input logic line_end,
    input logic std_q
);

    // R1: the tick that ends a line starts the next horizontal sync pulse.
    p_hsync_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> $fell(hsync_n));

    // R6: the frame pulse opens on a line start together with a sync pulse.
    p_frame_on_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame) |-> (!hsync_n && !msync_n));

    // R7: vertical drive opens with mixed sync already low.
    p_vdrive_on_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vdrive) |-> !msync_n);

    // R8: without a tick, no output moves.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(msync_n) && $stable(hsync_n) &&
                      $stable(vdrive) && $stable(frame)));

    // R9: the latched standard changes only as a frame begins.
    p_std_at_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(std_q) |-> frame);

endmodule

bind ilace_sync_gen ilace_sync_gen_chk u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .tick_en  (tick_en_i),
    .msync_n  (msync_no),
    .hsync_n  (hsync_no),
    .vdrive   (vdrive_o),
    .frame    (frame_o),
    .line_end (line_end),
    .std_q    (std_q)
);

// File: tb/ilace_sync_gen_test.sv
// Self-checking bench. An arithmetic raster model is stepped alongside the
// design, and every output is compared on every cycle across whole frames.
module ilace_sync_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n;
    logic tick_en;
    logic std625;
    logic vrst_eq;
    logic vrst_vs;
    logic msync_n;
    logic hsync_n;
    logic vdrive;
    logic frame;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    // Model state: tick in line, half-line, standard, pending requests.
    int mh, mv;
    bit mstd, mpe, mpv;
    bit last_tick;

    // Frame period measurement taken from the port.
    int  ticks_since = 0;
    int  last_period = 0;
    bit  prev_frame  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ilace_sync_gen uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_en_i (tick_en),
        .std625_i  (std625),
        .vrst_eq_i (vrst_eq),
        .vrst_vs_i (vrst_vs),
        .msync_no  (msync_n),
        .hsync_no  (hsync_n),
        .vdrive_o  (vdrive),
        .frame_o   (frame)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d (h=%0d v=%0d)",
                     tag, what, act, exp, mh, mv);
        end
    endtask

    // Advance the model across one clock edge with the given inputs.
    task automatic model_edge(input bit t, input bit e, input bit v, input bit s);
        int last;
        last = (mstd ? 625 : 525) * 2 - 1;
        if (t && mh == 31) begin
            if (mpe || e) begin
                mv = 0; mstd = s;
            end else if (mpv || v) begin
                mv = 6;
            end else if (mv == last) begin
                mv = 0; mstd = s;
            end else begin
                mv = mv + 1;
            end
            mpe = 0; mpv = 0;
        end else begin
            mpe = mpe | e;
            mpv = mpv | v;
            if (t && mh == 15) mv = mv + 1;
        end
        if (t) mh = (mh + 1) % 32;
    endtask

    // Compare all four outputs against values derived from the model position.
    task automatic compare_all();
        int    l, off, pos;
        bit    ehs, ems, efr, evd;
        string mtag;
        l   = mstd ? 625 : 525;
        off = (mv >= l) ? mv - l : mv;
        pos = mh % 16;
        ehs = !(mh < 2);
        efr = (mv == 0);
        evd = (off >= 6 && off < 12);
        if (off < 6 || (off >= 12 && off < 18)) begin
            ems = !(pos < 1); mtag = "R4";
        end else if (evd) begin
            ems = !(pos < 14); mtag = "R5";
        end else begin
            ems = ehs; mtag = "R3";
        end
        check(hsync_n == ehs, last_tick ? "R1" : "R8", "hsync_n", hsync_n, ehs);
        check(msync_n == ems, last_tick ? mtag : "R8", "msync_n", msync_n, ems);
        check(frame == efr, last_tick ? "R6" : "R8", "frame", frame, efr);
        check(vdrive == evd, last_tick ? "R7" : "R8", "vdrive", vdrive, evd);
    endtask

    // One clock: drive inputs, take the edge, sample at the falling edge.
    task automatic step(input bit t, input bit e, input bit v);
        tick_en = t; vrst_eq = e; vrst_vs = v;
        @(posedge clk);
        model_edge(t, e, v, std625);
        @(negedge clk);
        vrst_eq = 1'b0; vrst_vs = 1'b0;
        last_tick = t;
        compare_all();
        if (t) ticks_since++;
        if (frame && !prev_frame) begin
            last_period = ticks_since;
            ticks_since = 0;
        end
        prev_frame = frame;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic goto_tick(input int k);
        while (mh != k) step(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL R8 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        int n, k;
        rst_n = 1'b0; tick_en = 1'b0; std625 = 1'b0;
        vrst_eq = 1'b0; vrst_vs = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mh = 0; mv = 0; mstd = 0; mpe = 0; mpv = 0; last_tick = 1'b1;
        prev_frame = 1'b1;

        // R12: reset places the raster at tick 0 of half-line 0.
        check(hsync_n == 1'b0, "R12", "hsync_n after reset", hsync_n, 0);
        check(msync_n == 1'b0, "R12", "msync_n after reset", msync_n, 0);
        check(frame == 1'b1,   "R12", "frame after reset", frame, 1);
        check(vdrive == 1'b0,  "R12", "vdrive after reset", vdrive, 0);

        // R2: one full 525-line frame, every cycle compared.
        run(16800);
        check(last_period == 16800, "R2", "525 frame period", last_period, 16800);

        // R9: select 625 in mid-frame; this frame keeps 525 timing.
        run(1000);
        std625 = 1'b1;
        run(15800);
        check(last_period == 16800, "R9", "frame after mid-frame switch", last_period, 16800);

        // R2: a full 625-line frame.
        run(20000);
        check(last_period == 20000, "R2", "625 frame period", last_period, 20000);

        // R8: irregular tick enable pattern.
        for (int i = 0; i < 300; i++) step((i % 3) != 0, 1'b0, 1'b0);

        // R10: equalizing-target strobe waits for the end of the line.
        run(500);
        goto_tick(10);
        k = mh;
        step(1'b1, 1'b1, 1'b0);
        n = 1;
        while (!frame && n < 100) begin step(1'b1, 1'b0, 1'b0); n++; end
        check(n == 32 - k, "R10", "ticks to frame after eq strobe", n, 32 - k);

        // R11: vertical-target strobe raises vertical drive at the line end.
        run(1000);
        goto_tick(7);
        k = mh;
        step(1'b1, 1'b0, 1'b1);
        n = 1;
        while (!vdrive && n < 100) begin step(1'b1, 1'b0, 1'b0); n++; end
        check(n == 32 - k, "R11", "ticks to vdrive after vs strobe", n, 32 - k);

        // R11: both requests pending on one line; the equalizing target wins.
        run(1000);
        goto_tick(2);
        k = mh;
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        n = 3;
        while (!frame && n < 100) begin step(1'b1, 1'b0, 1'b0); n++; end
        check(n == 32 - k, "R11", "eq target wins over vs", n, 32 - k);
        check(vdrive == 1'b0, "R11", "vdrive low after eq wins", vdrive, 0);

        // R10: a strobe given while ticks are paused is held until applied.
        run(800);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        k = mh;
        n = 0;
        while (!frame && n < 100) begin step(1'b1, 1'b0, 1'b0); n++; end
        check(n == 32 - k, "R10", "held strobe applied", n, 32 - k);

        // R9: return to 525 and sweep a further frame.
        std625 = 1'b0;
        run(20000 + 16800);
        check(last_period == 16800, "R9", "525 frame after switch back", last_period, 16800);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule